// File: doc/BRIEF.md
# I2C Serial Clock Divider with SDA Hold Strobe

This block derives I2C serial clock timing from the system clock. A 6-bit divider code is split into two 3-bit indices. One index picks a pair of tap counts, one for the SCL tap chain and one for the SDA tap chain. The other index picks an offset and a per-tap multiplier. From these four values the block computes the length of one SCL period and the SDA hold delay, both counted in system clocks.

While enabled, the block produces a free-running SCL level. Each period starts with a high half and ends with an equally long low half. In every low half it raises a one-cycle strobe at the point where SDA may change. A controller uses the level to drive its clock pin and the strobe to move its data pin.

A new code takes effect only when a period boundary is reached. While the enable is low, SCL rests high and the counters are cleared.

Top module: `sclk_div_gen`

## Requirements
- R1: Code bits {5,1,0} (bit 5 most significant) form index A. Index A values 0 to 7 select the (SCL taps, SDA taps) pairs (9,3), (10,3), (12,4), (15,4), (5,1), (6,1), (7,2), (8,2), in that order.
- R2: Code bits {4,3,2} (bit 4 most significant) form index B. Index B values 0 to 7 select the (offset, multiplier) pairs (4,1), (4,2), (6,4), (6,8), (14,16), (30,32), (62,64), (126,128), in that order.
- R3: The period in system clocks is 2 × (offset + (SCL taps − 1) × multiplier + 2). For example, code 0x00 gives 28, code 0x20 gives 20, code 0x3F gives 2048 and code 0x1F gives 3840. While a period runs, `period_o` shows the period in force. It is always even and never below 20.
- R4: The SDA hold in system clocks is offset + (SDA taps − 1) × multiplier + 3. For example, code 0x00 gives 9, code 0x20 gives 7, code 0x3F gives 257 and code 0x1F gives 513.
- R5: The first period begins with the first clock edge at which `en` is sampled high. Each period drives `scl_o` high for exactly half the period and then low for the other half. The next period follows without a gap and starts high.
- R6: `sda_chg_o` is high for exactly one clock per period. It rises exactly hold clocks after `scl_o` falls, and it is never high while `scl_o` is high.
- R7: A change of `div_code` in the middle of a period does not alter that period's length, its high half or `period_o`. The new code applies from the next period boundary.
- R8: With `en` sampled low, the next cycle shows `scl_o` high, `sda_chg_o` low and `period_o` equal to 0. This state holds for as long as `en` stays low, and a later enable starts a full new period.
- R9: After reset, `scl_o` is 1, `sda_chg_o` is 0 and `period_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Runs the divider when high; idles it when low |
| div_code | input | 6 | Divider code, sampled at period boundaries |
| scl_o | output | 1 | SCL level (1 = released high) |
| sda_chg_o | output | 1 | One-cycle strobe marking when SDA may change |
| period_o | output | PER_W (12) | Period in force, in system clocks; 0 when idle |

## Verification
The bench builds the block with its default widths: a 12-bit period and a 10-bit hold. These widths cover the whole code space, including the longest period of 3840 clocks and the largest hold of 513 clocks that code 0x1F selects. Every SCL-tap index and every offset index is driven at least once. This lets each decode entry, the extreme periods and the upper bits of the counters be seen at the ports. Directed runs then change the code in the middle of a period and drop the enable during a low half.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

    localparam int CODE_W = 6;

    // Decoded tap-chain settings for one divider code.
    typedef struct packed {
        logic [3:0] scl_taps;   // SCL tap count, 5..15
        logic [2:0] sda_taps;   // SDA tap count, 1..4
        logic [6:0] offset;     // scl-to-tap offset, 4..126
        logic [7:0] mult;       // tap-to-tap multiplier, 1..128
    } tap_set_t;

endpackage

// File: rtl/sclk_code_decode.sv
module sclk_code_decode
    import sclk_div_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output tap_set_t          taps_o
);

    logic [2:0] idx_a;
    logic [2:0] idx_b;

    // The index bits are scattered across the code word.
    assign idx_a = {code_i[5], code_i[1], code_i[0]};
    assign idx_b = {code_i[4], code_i[3], code_i[2]};

    always_comb begin
        case (idx_a)
            3'd0:    begin taps_o.scl_taps = 4'd9;  taps_o.sda_taps = 3'd3; end
            3'd1:    begin taps_o.scl_taps = 4'd10; taps_o.sda_taps = 3'd3; end
            3'd2:    begin taps_o.scl_taps = 4'd12; taps_o.sda_taps = 3'd4; end
            3'd3:    begin taps_o.scl_taps = 4'd15; taps_o.sda_taps = 3'd4; end
            3'd4:    begin taps_o.scl_taps = 4'd5;  taps_o.sda_taps = 3'd1; end
            3'd5:    begin taps_o.scl_taps = 4'd6;  taps_o.sda_taps = 3'd1; end
            3'd6:    begin taps_o.scl_taps = 4'd7;  taps_o.sda_taps = 3'd2; end
            default: begin taps_o.scl_taps = 4'd8;  taps_o.sda_taps = 3'd2; end
        endcase

        case (idx_b)
            3'd0:    begin taps_o.offset = 7'd4;   taps_o.mult = 8'd1;   end
            3'd1:    begin taps_o.offset = 7'd4;   taps_o.mult = 8'd2;   end
            3'd2:    begin taps_o.offset = 7'd6;   taps_o.mult = 8'd4;   end
            3'd3:    begin taps_o.offset = 7'd6;   taps_o.mult = 8'd8;   end
            3'd4:    begin taps_o.offset = 7'd14;  taps_o.mult = 8'd16;  end
            3'd5:    begin taps_o.offset = 7'd30;  taps_o.mult = 8'd32;  end
            3'd6:    begin taps_o.offset = 7'd62;  taps_o.mult = 8'd64;  end
            default: begin taps_o.offset = 7'd126; taps_o.mult = 8'd128; end
        endcase
    end

endmodule

// File: rtl/sclk_timing_calc.sv
module sclk_timing_calc
    import sclk_div_pkg::*;
#(
    parameter int PER_W  = 12,
    parameter int HOLD_W = 10
) (
    input  tap_set_t          taps_i,
    output logic [PER_W-1:0]  period_o,
    output logic [PER_W-1:0]  half_o,
    output logic [HOLD_W-1:0] hold_o
);

    localparam int HALF_W = PER_W - 1;

    logic [HALF_W-1:0] half_w;

    // Half period: offset + (SCL taps - 1) * mult + 2
    assign half_w = HALF_W'(taps_i.offset)
                  + HALF_W'(taps_i.scl_taps - 4'd1) * HALF_W'(taps_i.mult)
                  + HALF_W'(2);

    assign half_o   = {1'b0, half_w};
    assign period_o = {half_w, 1'b0};

    // Hold after falling SCL: offset + (SDA taps - 1) * mult + 3
    assign hold_o = HOLD_W'(taps_i.offset)
                  + HOLD_W'(taps_i.sda_taps - 3'd1) * HOLD_W'(taps_i.mult)
                  + HOLD_W'(3);

endmodule

// File: rtl/sclk_div_gen.sv
module sclk_div_gen
    import sclk_div_pkg::*;
#(
    parameter int PER_W  = 12,
    parameter int HOLD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CODE_W-1:0] div_code,
    output logic              scl_o,
    output logic              sda_chg_o,
    output logic [PER_W-1:0]  period_o
);

    typedef struct packed {
        logic             run;
        logic [PER_W-1:0] cnt;
        logic [PER_W-1:0] per;
        logic [PER_W-1:0] half;
        logic [PER_W-1:0] chg_at;
        logic             scl;
        logic             strb;
    } state_t;

    tap_set_t          taps;
    logic [PER_W-1:0]  new_per;
    logic [PER_W-1:0]  new_half;
    logic [HOLD_W-1:0] new_hold;
    state_t            st_d;
    state_t            st_q;

    sclk_code_decode u_decode (
        .code_i (div_code),
        .taps_o (taps)
    );

    sclk_timing_calc #(
        .PER_W  (PER_W),
        .HOLD_W (HOLD_W)
    ) u_calc (
        .taps_i   (taps),
        .period_o (new_per),
        .half_o   (new_half),
        .hold_o   (new_hold)
    );

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.run    = 1'b0;
            st_d.cnt    = '0;
            st_d.per    = '0;
            st_d.half   = '0;
            st_d.chg_at = '0;
        end else if (!st_q.run || (st_q.cnt == st_q.per - PER_W'(1))) begin
            // Period boundary: the only point where a new code is taken.
            st_d.run    = 1'b1;
            st_d.cnt    = '0;
            st_d.per    = new_per;
            st_d.half   = new_half;
            st_d.chg_at = new_half + PER_W'(new_hold);
        end else begin
            st_d.cnt = st_q.cnt + PER_W'(1);
        end
        st_d.scl  = !st_d.run || (st_d.cnt < st_d.half);
        st_d.strb = st_d.run && (st_d.cnt == st_d.chg_at);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.scl    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_o     = st_q.scl;
    assign sda_chg_o = st_q.strb;
    assign period_o  = st_q.per;

endmodule

// File: rtl/sclk_div_chk.sv
module sclk_div_chk #(
    parameter int PER_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             scl_o,
    input logic             sda_chg_o,
    input logic [PER_W-1:0] period_o
);

    assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (scl_o && !sda_chg_o && period_o == '0));

    assert_chg_in_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sda_chg_o |-> !scl_o);

    assert_chg_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sda_chg_o |=> !sda_chg_o);

    assert_even_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        period_o[0] == 1'b0);

    assert_min_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (period_o != '0) |-> (period_o >= PER_W'(20)));

    assert_no_swap_at_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_o) |-> $stable(period_o));

endmodule

bind sclk_div_gen sclk_div_chk #(.PER_W(PER_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .scl_o     (scl_o),
    .sda_chg_o (sda_chg_o),
    .period_o  (period_o)
);

// File: tb/sclk_div_gen_tb.sv
module sclk_div_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [5:0]  div_code = 6'd0;
    logic        scl_o;
    logic        sda_chg_o;
    logic [11:0] period_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    sclk_div_gen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .div_code  (div_code),
        .scl_o     (scl_o),
        .sda_chg_o (sda_chg_o),
        .period_o  (period_o)
    );

    // code, expected period, expected hold (worked out by hand from R1..R4)
    localparam int NV = 17;
    localparam int V_CODE[NV] = '{'h00, 'h3F, 'h20, 'h01, 'h02, 'h03, 'h21, 'h22, 'h23,
                                  'h04, 'h08, 'h0C, 'h10, 'h14, 'h18, 'h1C, 'h1F};
    localparam int V_PER [NV] = '{28, 2048, 20, 30, 34, 40, 22, 24, 26,
                                  44, 80, 144, 288, 576, 1152, 2304, 3840};
    localparam int V_HOLD[NV] = '{9, 257, 7, 9, 10, 10, 7, 8, 8,
                                  11, 17, 25, 49, 97, 193, 385, 513};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic run_vec(input logic [5:0] c, input int p, input int d);
        int hi = 0;
        int fall = -1;
        int strb_at = -1;
        int nstrb = 0;
        int in_high = 0;
        en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        div_code = c;
        en = 1'b1;
        @(negedge clk);
        for (int i = 0; i <= p; i++) begin
            if (i == 0) chk(period_o == 12'(p), "R1 R2 R3 period", int'(period_o), p);
            if (i < p) begin
                if (scl_o) hi++;
                if (!scl_o && fall < 0) fall = i;
                if (sda_chg_o) begin
                    nstrb++;
                    strb_at = i;
                    if (scl_o) in_high++;
                end
            end else begin
                chk(scl_o == 1'b1, "R5 next period starts high", int'(scl_o), 1);
            end
            @(negedge clk);
        end
        chk(hi == p / 2, "R5 high half", hi, p / 2);
        chk(fall == p / 2, "R5 fall point", fall, p / 2);
        chk(strb_at - fall == d, "R1 R2 R4 R6 hold", strb_at - fall, d);
        chk(nstrb == 1, "R6 one strobe per period", nstrb, 1);
        chk(in_high == 0, "R6 strobe outside high half", in_high, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(scl_o == 1'b1, "R9 scl reset", int'(scl_o), 1);
        chk(sda_chg_o == 1'b0, "R9 strobe reset", int'(sda_chg_o), 0);
        chk(period_o == 12'd0, "R9 period reset", int'(period_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(scl_o == 1'b1 && period_o == 12'd0, "R8 idle before enable", int'(period_o), 0);

        // Table walk covering every index of both fields
        for (int v = 0; v < NV; v++) begin
            run_vec(6'(V_CODE[v]), V_PER[v], V_HOLD[v]);
        end

        // R7: code change in the middle of a period
        en = 1'b0;
        @(negedge clk);
        div_code = 6'h00;
        en = 1'b1;
        @(negedge clk);
        for (int i = 0; i <= 45; i++) begin
            if (i == 5) div_code = 6'h20;
            if (i == 14) chk(scl_o == 1'b0, "R7 old half kept", int'(scl_o), 0);
            if (i == 13) chk(scl_o == 1'b1, "R7 old high kept", int'(scl_o), 1);
            if (i == 27) chk(period_o == 12'd28, "R7 old period kept", int'(period_o), 28);
            if (i == 28) chk(period_o == 12'd20 && scl_o, "R7 new period at boundary", int'(period_o), 20);
            if (i == 37) chk(scl_o == 1'b1, "R7 new high half", int'(scl_o), 1);
            if (i == 38) chk(scl_o == 1'b0, "R7 new fall", int'(scl_o), 0);
            if (i == 45) chk(sda_chg_o == 1'b1, "R7 R6 new hold", int'(sda_chg_o), 1);
            @(negedge clk);
        end

        // R8: drop enable during a low half, then restart
        en = 1'b0;
        @(negedge clk);
        div_code = 6'h00;
        en = 1'b1;
        @(negedge clk);
        repeat (20) @(negedge clk);
        chk(scl_o == 1'b0, "R8 setup in low half", int'(scl_o), 0);
        en = 1'b0;
        @(negedge clk);
        chk(scl_o == 1'b1 && !sda_chg_o, "R8 idle level", int'(scl_o), 1);
        chk(period_o == 12'd0, "R8 idle period", int'(period_o), 0);
        begin
            int lows = 0;
            for (int k = 0; k < 12; k++) begin
                if (!scl_o || sda_chg_o) lows++;
                @(negedge clk);
            end
            chk(lows == 0, "R8 stays idle", lows, 0);
        end
        en = 1'b1;
        @(negedge clk);
        chk(period_o == 12'd28 && scl_o, "R8 restart period", int'(period_o), 28);
        repeat (13) @(negedge clk);
        chk(scl_o == 1'b1, "R8 restart full high", int'(scl_o), 1);
        @(negedge clk);
        chk(scl_o == 1'b0, "R8 restart fall", int'(scl_o), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule